// File: doc/BRIEF.md
# Pipeline Debug Entry Controller

This block decides when a three-stage fetch/decode/execute core stops and enters debug state. A breakpoint match seen at fetch is stored as a one-bit tag that moves down the pipeline with its instruction. Nothing happens until that instruction reaches execute. The block then suppresses the instruction and either requests debug entry (halt mode) or raises a prefetch-abort request (monitor mode). Any pipeline flush discards every tag that has not yet reached execute. If the same address is fetched again later, the fetch comparator matches it again and it is tagged again.

Watchpoint hits on data accesses are always latched. They act only once the core reports that the current instruction has fully retired, including every beat of a multi-register transfer and all of its writebacks. In halt mode the result is a debug-entry request. In monitor mode it is a data-abort request. A debug entry sets a sticky in-debug flag and records a cause code. It also records the processor mode the core will halt in, which is the pending exception's mode when an exception is waiting.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: A tag is set when `fetch_valid_i` and `bkpt_match_i` are high in a cycle where `advance_i` is high. The tag moves one stage per `advance_i`. `exec_suppress_o` is high exactly while the instruction in execute carries a tag.
- R2: In halt mode (`monitor_mode_i`=0), when the instruction in execute is tagged and the block is not in debug, the next edge does four things: `dbg_req_o` pulses for one cycle, `in_debug_o` sets, `cause_o` becomes 2'b01 (breakpoint), and the tag is consumed.
- R3: `flush_i` clears every tag in the pipeline, so a flushed tagged instruction never causes debug entry.
- R4: After a flush, a tagged instruction fetched again is carried and acted on normally.
- R5: A watchpoint hit is latched. Debug entry waits for `instr_done_i`. The entry then happens at the following edge with `cause_o`=2'b10 (watchpoint), however many cycles `instr_done_i` takes to arrive.
- R6: A watchpoint hit and `instr_done_i` in the same cycle cause entry at the next edge.
- R7: If a breakpoint in execute and a completed watchpoint are ready in the same cycle, the watchpoint is reported (`cause_o`=2'b10). The breakpoint tag stays and is taken after restart.
- R8: `in_debug_o` holds until `restart_i`. No new `dbg_req_o` is raised while it is set. `cause_o` holds its value between entries.
- R9: In monitor mode, a tagged instruction in execute produces a one-cycle `pabort_o` pulse at the next edge and consumes the tag. No debug entry occurs.
- R10: In monitor mode, a completed watchpoint produces a one-cycle `dabort_o` pulse instead of debug entry.
- R11: At each entry, `dbg_mode_o` captures `exc_mode_i` if `exc_pending_i` is high, and `cur_mode_i` otherwise.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | An instruction is fetched this cycle |
| bkpt_match_i | input | 1 | The fetched address matches a breakpoint |
| advance_i | input | 1 | Pipeline moves one stage |
| flush_i | input | 1 | Branch, PC write or exception flush |
| wp_match_i | input | 1 | Data access matches a watchpoint |
| instr_done_i | input | 1 | The current instruction has fully retired |
| monitor_mode_i | input | 1 | 1 = monitor (abort), 0 = halt |
| restart_i | input | 1 | Leave debug state |
| exc_pending_i | input | 1 | An exception is pending |
| exc_mode_i | input | MODE_W | Mode of the pending exception |
| cur_mode_i | input | MODE_W | Current processor mode |
| exec_suppress_o | output | 1 | Do not execute the instruction in execute |
| dbg_req_o | output | 1 | One-cycle debug-entry request |
| in_debug_o | output | 1 | Sticky in-debug flag |
| cause_o | output | 2 | 01 breakpoint, 10 watchpoint, 00 none yet |
| dbg_mode_o | output | MODE_W | Mode to enter debug in |
| pabort_o | output | 1 | Prefetch-abort request (monitor) |
| dabort_o | output | 1 | Data-abort request (monitor) |

## Verification
The hardest case to reach is the collision where a breakpoint sits in execute in the same cycle that a pending watchpoint retires. The stimulus builds it step by step: it fetches a tagged instruction, then advances it into execute in the same cycle as a watchpoint hit. It then raises `instr_done_i` one cycle later. After the watchpoint entry and a restart, the bench confirms that the retained tag still produces a second, breakpoint-cause entry.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_BKPT = 2'b01,
    CAUSE_WP   = 2'b10
  } cause_e;
endpackage

// File: rtl/dbg_tag_pipe.sv
module dbg_tag_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tag_in_i,
  input  logic advance_i,
  input  logic flush_i,
  input  logic consume_i,
  output logic exe_tag_o
);
  logic [DEPTH-1:0] tag_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_first
      assign nxt = tag_in_i;
    end else begin : g_rest
      assign nxt = tag_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        tag_q[i] <= 1'b0;
      else if (flush_i)   tag_q[i] <= 1'b0;
      else if (advance_i) tag_q[i] <= nxt;
      else if (consume_i && i == DEPTH-1) tag_q[i] <= 1'b0;
    end
  end

  assign exe_tag_o = tag_q[DEPTH-1];
endmodule

// File: rtl/dbg_wp_track.sv
module dbg_wp_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wp_match_i,
  input  logic instr_done_i,
  input  logic take_i,
  output logic ready_o
);
  logic pend_q;

  assign ready_o = (pend_q | wp_match_i) & instr_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (take_i)     pend_q <= 1'b0;
    else if (wp_match_i) pend_q <= 1'b1;
  end
endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
  import dbg_entry_pkg::*;
#(
  parameter int MODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bp_ready_i,
  input  logic              wp_ready_i,
  input  logic              monitor_i,
  input  logic              restart_i,
  input  logic              exc_pending_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  output logic              bp_take_o,
  output logic              wp_take_o,
  output logic              dbg_req_o,
  output logic              in_debug_o,
  output cause_e            cause_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              pabort_o,
  output logic              dabort_o
);
  logic              req_q, dbg_q, pab_q, dab_q;
  cause_e            cause_q;
  logic [MODE_W-1:0] mode_q;
  logic              enter;

  // watchpoint is the older access: it wins in halt mode
  always_comb begin
    wp_take_o = wp_ready_i && (monitor_i || !dbg_q);
    bp_take_o = bp_ready_i && (monitor_i || (!dbg_q && !wp_ready_i));
    enter     = !monitor_i && (wp_take_o || bp_take_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      dbg_q   <= 1'b0;
      pab_q   <= 1'b0;
      dab_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      mode_q  <= '0;
    end else begin
      req_q <= enter;
      pab_q <= monitor_i && bp_take_o;
      dab_q <= monitor_i && wp_take_o;
      if (enter) begin
        dbg_q   <= 1'b1;
        cause_q <= wp_take_o ? CAUSE_WP : CAUSE_BKPT;
        mode_q  <= exc_pending_i ? exc_mode_i : cur_mode_i;
      end else if (restart_i) begin
        dbg_q <= 1'b0;
      end
    end
  end

  assign dbg_req_o  = req_q;
  assign in_debug_o = dbg_q;
  assign cause_o    = cause_q;
  assign mode_o     = mode_q;
  assign pabort_o   = pab_q;
  assign dabort_o   = dab_q;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int MODE_W    = 5,
  parameter int TAG_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic              bkpt_match_i,
  input  logic              advance_i,
  input  logic              flush_i,
  input  logic              wp_match_i,
  input  logic              instr_done_i,
  input  logic              monitor_mode_i,
  input  logic              restart_i,
  input  logic              exc_pending_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  output logic              exec_suppress_o,
  output logic              dbg_req_o,
  output logic              in_debug_o,
  output logic [1:0]        cause_o,
  output logic [MODE_W-1:0] dbg_mode_o,
  output logic              pabort_o,
  output logic              dabort_o
);
  logic   exe_tag, wp_ready, bp_take, wp_take;
  cause_e cause;

  dbg_tag_pipe #(.DEPTH(TAG_DEPTH)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_in_i  (fetch_valid_i & bkpt_match_i),
    .advance_i (advance_i),
    .flush_i   (flush_i),
    .consume_i (bp_take),
    .exe_tag_o (exe_tag)
  );

  dbg_wp_track u_wp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wp_match_i   (wp_match_i),
    .instr_done_i (instr_done_i),
    .take_i       (wp_take),
    .ready_o      (wp_ready)
  );

  dbg_entry_arb #(.MODE_W(MODE_W)) u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bp_ready_i    (exe_tag),
    .wp_ready_i    (wp_ready),
    .monitor_i     (monitor_mode_i),
    .restart_i     (restart_i),
    .exc_pending_i (exc_pending_i),
    .exc_mode_i    (exc_mode_i),
    .cur_mode_i    (cur_mode_i),
    .bp_take_o     (bp_take),
    .wp_take_o     (wp_take),
    .dbg_req_o     (dbg_req_o),
    .in_debug_o    (in_debug_o),
    .cause_o       (cause),
    .mode_o        (dbg_mode_o),
    .pabort_o      (pabort_o),
    .dabort_o      (dabort_o)
  );

  assign exec_suppress_o = exe_tag;
  assign cause_o         = cause;
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       instr_done_i,
  input logic       monitor_mode_i,
  input logic       restart_i,
  input logic       dbg_req_o,
  input logic       in_debug_o,
  input logic [1:0] cause_o,
  input logic       pabort_o,
  input logic       dabort_o
);
  // R2
  req_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |=> !dbg_req_o);

  // R8
  req_sets_debug_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |-> in_debug_o);

  // R8
  debug_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_debug_o && !restart_i) |=> (in_debug_o && !dbg_req_o));

  // R5
  wp_waits_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_done_i |=> !(dbg_req_o && cause_o == 2'b10));

  // R9
  halt_no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !monitor_mode_i |=> (!pabort_o && !dabort_o));

  // R10
  monitor_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    monitor_mode_i |=> !dbg_req_o);
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk chk_i (.*);

// File: tb/dbg_entry_ctrl_tb_top.sv
module dbg_entry_ctrl_tb_top;
  localparam int MW = 5;
  localparam int NV = 31;
  localparam logic [MW-1:0] CUR = 5'h13;
  localparam logic [MW-1:0] EXC = 5'h17;

  logic clk = 0, rst_n = 0;
  logic fv = 0, bk = 0, adv = 0, fl = 0, wp = 0, dn = 0, mo = 0, rs = 0;
  logic ep = 0;
  logic exs, req, ind, pab, dab;
  logic [1:0] cause;
  logic [MW-1:0] dmode;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  dbg_entry_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .bkpt_match_i(bk),
    .advance_i(adv), .flush_i(fl), .wp_match_i(wp), .instr_done_i(dn),
    .monitor_mode_i(mo), .restart_i(rs), .exc_pending_i(ep),
    .exc_mode_i(EXC), .cur_mode_i(CUR), .exec_suppress_o(exs),
    .dbg_req_o(req), .in_debug_o(ind), .cause_o(cause), .dbg_mode_o(dmode),
    .pabort_o(pab), .dabort_o(dab));

  // {req id, inputs fv bk adv fl wp dn mo rs, expect exs req ind cause[1:0] pab dab}
  localparam logic [18:0] VEC [NV] = '{
    {4'd1,  8'b1110_0000, 7'b000_00_00},  // R1 tag into decode
    {4'd1,  8'b0010_0000, 7'b100_00_00},  // R1 tag in execute
    {4'd2,  8'b0000_0000, 7'b011_01_00},  // R2 entry
    {4'd8,  8'b0000_0000, 7'b001_01_00},  // R8 sticky, no repeat
    {4'd8,  8'b0000_0001, 7'b000_01_00},  // R8 restart
    {4'd3,  8'b1110_0000, 7'b000_01_00},  // R3
    {4'd3,  8'b0001_0000, 7'b000_01_00},  // R3 flush
    {4'd3,  8'b0010_0000, 7'b000_01_00},  // R3
    {4'd3,  8'b0000_0000, 7'b000_01_00},  // R3 no entry
    {4'd4,  8'b1110_0000, 7'b000_01_00},  // R4 refetch
    {4'd4,  8'b0010_0000, 7'b100_01_00},  // R4
    {4'd4,  8'b0000_0000, 7'b011_01_00},  // R4
    {4'd8,  8'b0000_0001, 7'b000_01_00},  // R8
    {4'd5,  8'b0000_1000, 7'b000_01_00},  // R5 hit, not done
    {4'd5,  8'b0000_0000, 7'b000_01_00},  // R5
    {4'd5,  8'b0000_0000, 7'b000_01_00},  // R5
    {4'd5,  8'b0000_0100, 7'b011_10_00},  // R5 retire
    {4'd8,  8'b0000_0001, 7'b000_10_00},  // R8
    {4'd6,  8'b0000_1100, 7'b011_10_00},  // R6
    {4'd8,  8'b0000_0001, 7'b000_10_00},  // R8
    {4'd7,  8'b1110_0000, 7'b000_10_00},  // R7
    {4'd7,  8'b0010_1000, 7'b100_10_00},  // R7 tag in exe + wp
    {4'd7,  8'b0000_0100, 7'b111_10_00},  // R7 wp wins
    {4'd7,  8'b0000_0001, 7'b100_10_00},  // R7 restart
    {4'd7,  8'b0000_0000, 7'b011_01_00},  // R7 bp after
    {4'd8,  8'b0000_0001, 7'b000_01_00},  // R8
    {4'd9,  8'b1110_0010, 7'b000_01_00},  // R9
    {4'd9,  8'b0010_0010, 7'b100_01_00},  // R9
    {4'd9,  8'b0000_0010, 7'b000_01_10},  // R9 pabort
    {4'd10, 8'b0000_1110, 7'b000_01_01},  // R10 dabort
    {4'd10, 8'b0000_0010, 7'b000_01_00}   // R10 pulse ends
  };

  task automatic chk(input int rid, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", rid, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {fv, bk, adv, fl, wp, dn, mo, rs} = v;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk(12, {25'd0, exs, req, ind, cause, pab, dab}, 32'd0);
    chk(12, {27'd0, dmode}, 32'd0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][14:7]);
      step();
      chk(int'(VEC[i][18:15]), {25'd0, exs, req, ind, cause, pab, dab},
          {25'd0, VEC[i][6:0]});
    end

    // R11 watchpoint entry with pending exception picks exception mode
    @(negedge clk); drive(8'b0000_1100); ep = 1;
    step();
    chk(11, {31'd0, req}, 32'd1);
    chk(11, {27'd0, dmode}, {27'd0, EXC});
    @(negedge clk); drive(8'b0000_0001); ep = 0;
    step();
    // R11 breakpoint entry without pending exception picks current mode
    @(negedge clk); drive(8'b1110_0000); step();
    @(negedge clk); drive(8'b0010_0000); step();
    @(negedge clk); drive(8'b0000_0000); step();
    chk(11, {31'd0, req}, 32'd1);
    chk(11, {27'd0, dmode}, {27'd0, CUR});
    // R8 restart alone leaves mode and cause
    @(negedge clk); drive(8'b0000_0001); step();
    chk(8, {30'd0, cause}, 32'd1);
    chk(8, {31'd0, ind}, 32'd0);

    // R12 asynchronous reset mid-debug
    @(negedge clk); drive(8'b0000_1100); step();
    #2 rst_n = 0; #1;
    chk(12, {25'd0, exs, req, ind, cause, pab, dab}, 32'd0);
    @(negedge clk); rst_n = 1; drive(8'd0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule